// File: doc/BRIEF.md
# Breakpoint Halt and Status Controller

This block turns an external breakpoint request into one of two debug actions. By default, a breakpoint stops the core: the request is held pending until the instruction in flight retires, and then the halt request output is raised. A mode bit can redirect the same breakpoint so that it raises a one-cycle debug-interrupt request instead of a halt. This lets software keep running and service the breakpoint itself.

The block also owns the processor-status bus. While the core runs, the bus carries the pipeline's own status value unchanged. While the core is halted, a fixed halt code replaces that value, so an outside debugger can see the stopped state. A go pulse ends the halted state. The breakpoint input is edge-detected, so a pin that stays asserted produces exactly one event.

Top module: `brk_halt_ctl`

## Requirements
- R1: After reset, `halt_o` and `dbg_irq_o` are 0, no request is pending, and `stat_o` equals `pipe_stat_i`.
- R2: A rising edge of `brk_req_i` sampled with `brk_to_irq_i`=0 sets a pending halt. `halt_o` rises one cycle after the first clock edge at which `insn_done_i`=1 is sampled. It stays 0 until then.
- R3: While `halt_o`=1, `stat_o` equals the halt code 0x0F. While `halt_o`=0, `stat_o` equals `pipe_stat_i`.
- R4: A rising edge of `brk_req_i` sampled with `brk_to_irq_i`=1 sets a pending debug interrupt and never a halt. `dbg_irq_o` is 1 for exactly one cycle, starting one cycle after the first clock edge at which `insn_done_i`=1 is sampled.
- R5: Holding `brk_req_i` high produces a single halt or a single interrupt. No further event occurs until the pin falls and rises again.
- R6: `go_i`=1 sampled while halted clears `halt_o` on the next cycle. From that cycle on, `stat_o` returns to `pipe_stat_i`.
- R7: Rising edges of `brk_req_i` that arrive while the core is halted are ignored. After a later go, no halt or interrupt follows from them.
- R8: `go_i` has no effect while the core is not halted.
- R9: A rising edge of `brk_req_i` sampled at the same edge as `insn_done_i`=1 takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_req_i | input | 1 | External breakpoint request (level; edge-detected) |
| insn_done_i | input | 1 | Instruction-complete strobe |
| brk_to_irq_i | input | 1 | 1 redirects breakpoints to a debug interrupt |
| go_i | input | 1 | Resume pulse that leaves the halted state |
| pipe_stat_i | input | 8 | Normal processor status from the pipeline |
| halt_o | output | 1 | Core halt request / halted indication |
| dbg_irq_o | output | 1 | One-cycle debug-interrupt request |
| stat_o | output | 8 | Muxed processor status |

## Verification
On every cycle, the embedded assertions check three things. A halt only begins after an instruction-complete strobe, and an interrupt pulse only follows one. The interrupt pulse never lasts beyond one cycle. A go pulse seen while halted always ends the halt. The bench sweeps the delay between the breakpoint edge and the completion strobe in both modes. Only those scenarios can show the rest: that a held pin yields exactly one event, that edges arriving while halted leave nothing pending after the resume, and that the status bus passes every pipeline value except while halted.

// File: rtl/brk_halt_ctl.sv
module brk_halt_ctl #(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] HALT_CODE = STAT_W'(8'h0F)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req_i,
  input  logic              insn_done_i,
  input  logic              brk_to_irq_i,
  input  logic              go_i,
  input  logic [STAT_W-1:0] pipe_stat_i,
  output logic              halt_o,
  output logic              dbg_irq_o,
  output logic [STAT_W-1:0] stat_o
);

  logic brk_q, halted_q, pend_halt_q, pend_irq_q, irq_q;

  wire brk_rise  = brk_req_i & ~brk_q & ~halted_q;
  wire want_halt = pend_halt_q | (brk_rise & ~brk_to_irq_i);
  wire want_irq  = pend_irq_q  | (brk_rise &  brk_to_irq_i);
  wire retire    = insn_done_i & ~halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q       <= 1'b0;
      halted_q    <= 1'b0;
      pend_halt_q <= 1'b0;
      pend_irq_q  <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      brk_q       <= brk_req_i;
      pend_halt_q <= want_halt & ~retire;
      pend_irq_q  <= want_irq  & ~retire;
      irq_q       <= want_irq  &  retire;
      if (halted_q && go_i)
        halted_q <= 1'b0;
      else if (want_halt && retire)
        halted_q <= 1'b1;
    end
  end

  assign halt_o    = halted_q;
  assign dbg_irq_o = irq_q;
  assign stat_o    = halted_q ? HALT_CODE : pipe_stat_i;

  // R2
  halt_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> $past(insn_done_i));

  // R4
  irq_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_irq_o) |-> $past(insn_done_i));

  // R4
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq_o |=> !dbg_irq_o);

  // R6
  go_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && go_i) |=> !halt_o);

  // R2
  no_halt_without_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_o && !insn_done_i) |=> !halt_o);

endmodule

// File: tb/brk_halt_ctl_tb_top.sv
module brk_halt_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic brk = 1'b0, done = 1'b0, to_irq = 1'b0, go = 1'b0;
  logic [7:0] pst = 8'h00;
  logic halt, irq;
  logic [7:0] stat;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  brk_halt_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .brk_req_i(brk), .insn_done_i(done),
    .brk_to_irq_i(to_irq), .go_i(go), .pipe_stat_i(pst),
    .halt_o(halt), .dbg_irq_o(irq), .stat_o(stat));

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    pst = 8'h5A;
    #1;
    chk(halt == 0, "R1", halt, 0);
    chk(irq == 0, "R1", irq, 0);
    chk(stat == 8'h5A, "R1", stat, 8'h5A);
    tick();
    chk(halt == 0 && irq == 0, "R1", {halt, irq}, 0);

    // R8: go while running does nothing
    go = 1; tick(); go = 0; tick();
    chk(halt == 0, "R8", halt, 0);

    for (int p = 0; p < 256; p++) begin
      pst = 8'(p); #1;
      chk(stat == 8'(p), "R3", stat, p);
    end

    for (int mode = 0; mode < 2; mode++) begin
      for (int d = 0; d < 6; d++) begin
        to_irq = mode[0];
        brk = 1; done = (d == 0);
        tick();
        for (int k = 1; k <= d; k++) begin
          chk(halt == 0 && irq == 0, mode ? "R4" : "R2", {halt, irq}, 0);
          done = (k == d);
          tick();
        end
        done = 0;
        if (d == 0) chk(mode ? irq == 1 : halt == 1, "R9", {halt, irq}, mode ? 1 : 2);
        if (mode == 0) begin
          chk(halt == 1 && irq == 0, "R2", {halt, irq}, 2);
          pst = 8'(8'hA0 + d); #1;
          chk(stat == 8'h0F, "R3", stat, 8'h0F);
          for (int k = 0; k < 3; k++) begin done = 1; tick(); end
          done = 0;
          chk(halt == 1 && irq == 0, "R5", {halt, irq}, 2);
          brk = 0; tick();
          brk = 1; done = 1; tick();
          to_irq = 1; brk = 0; tick(); brk = 1; tick();
          to_irq = 0; done = 0;
          chk(halt == 1 && irq == 0, "R7", {halt, irq}, 2);
          go = 1; tick(); go = 0;
          chk(halt == 0, "R6", halt, 0);
          chk(stat == 8'(8'hA0 + d), "R6", stat, 8'hA0 + d);
          for (int k = 0; k < 3; k++) begin
            done = 1; tick();
            chk(halt == 0 && irq == 0, "R7", {halt, irq}, 0);
          end
          done = 0;
        end else begin
          chk(irq == 1 && halt == 0, "R4", {halt, irq}, 1);
          tick();
          chk(irq == 0, "R4", irq, 0);
          for (int k = 0; k < 3; k++) begin
            done = 1; tick();
            chk(irq == 0 && halt == 0, "R5", {halt, irq}, 0);
          end
          done = 0;
        end
        brk = 0; tick();
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule